// File: doc/BRIEF.md
# Mode-Register Address Override Shim

This block sits between a memory controller and a DDR2 DIMM, in the path of the command pins, the bank address and the row/column address. Some controllers cannot place an arbitrary bank and address pattern on the pins while they issue a mode-register load. The shim fills that gap. A host first loads two 8-bit override registers. Once the shim is armed, it swaps in the stored bank and address values on every cycle that decodes as LOAD MODE or PRECHARGE. All other cycles pass through untouched.

Every path through the shim is registered, so all outputs lag the inputs by exactly one clock. The override value for address bit 10 must already be in place before the precharge that directly precedes a load. The reason is that both commands are rewritten from the same stored contents, and the host gets no chance to write between them. Only the override fields are stored. The unused bits of the second register are discarded when it is written.

Top module: `mr_addr_shim`

## Requirements
- R1: After reset, both override registers are zero, so the override is off. The command outputs read deselect (all four high) and the bank and address outputs read zero.
- R2: A host write with `host_sel`=0 loads the low-address register, and `host_sel`=1 loads the control register. A command sampled on the same edge as a write still sees the previous contents. Commands sampled from the next edge onward see the new value.
- R3: The command outputs reproduce the command inputs one clock later on every cycle.
- R4: On any cycle that is not substituted, `ba_o` and `addr_o` reproduce `ba_i` and `addr_i` one clock later.
- R5: A cycle with `cs_n_i`, `ras_n_i`, `cas_n_i` and `we_n_i` all low is a LOAD MODE. When the override is armed, its bank and address are substituted.
- R6: A cycle with `cs_n_i`, `ras_n_i` and `we_n_i` low and `cas_n_i` high is a PRECHARGE. When the override is armed, its bank and address are substituted.
- R7: On a substituted cycle, `ba_o` equals control-register bits 6:5.
- R8: On a substituted cycle, `addr_o[7:0]` equals the low-address register, `addr_o[10]` equals control-register bit 2, and every other address bit is 0. Control value C4h gives bank 10b with bit 10 set; E0h gives bank 11b with bit 10 clear.
- R9: The override is armed only while control-register bit 7 is 1. With that bit at 0, LOAD MODE and PRECHARGE pass through like any other command.
- R10: Control-register bits 4, 3, 1 and 0 have no effect on any output.
- R11: A PRECHARGE followed directly by a LOAD MODE, with no write in between, gives both commands the same substituted bank and address, including bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 = low-address register, 1 = control register |
| host_wdata | input | 8 | Host write data |
| cs_n_i | input | 1 | Chip select from controller |
| ras_n_i | input | 1 | Row strobe from controller |
| cas_n_i | input | 1 | Column strobe from controller |
| we_n_i | input | 1 | Write enable from controller |
| ba_i | input | 2 | Bank address from controller |
| addr_i | input | 14 | Address from controller |
| cs_n_o | output | 1 | Chip select to DIMM |
| ras_n_o | output | 1 | Row strobe to DIMM |
| cas_n_o | output | 1 | Column strobe to DIMM |
| we_n_o | output | 1 | Write enable to DIMM |
| ba_o | output | 2 | Bank address to DIMM |
| addr_o | output | 14 | Address to DIMM |

## Verification
The hardest situation to reach from the ports is a host write that lands on the same edge as a LOAD MODE or PRECHARGE. In that case the command must use the old override contents, and the next command must use the new ones. The random phase issues writes and substituting commands independently, with high probability, so such collisions happen many times. A directed case forces one collision with values that differ in every field. A second directed pair sends a precharge directly into a load and compares both outputs against the same stored contents.

// File: rtl/shim_pkg.sv
package shim_pkg;

    // Interface widths
    localparam int SHIM_ADDR_W = 14;
    localparam int SHIM_BA_W   = 2;
    localparam int SHIM_REG_W  = 8;

    // Field positions inside the control register
    localparam int CTL_ARM_BIT = 7;
    localparam int CTL_BA_HI   = 6;
    localparam int CTL_BA_LO   = 5;
    localparam int CTL_A10_BIT = 2;

    // Address bit fed by the control register
    localparam int HI_ADDR_POS = 10;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    typedef enum logic [1:0] {
        CMD_PASS = 2'd0,
        CMD_LMR  = 2'd1,
        CMD_PRE  = 2'd2
    } cmd_kind_e;

    // Only the fields that drive outputs are kept
    typedef struct packed {
        logic                  arm;
        logic [SHIM_BA_W-1:0]  bank;
        logic                  a10;
        logic [SHIM_REG_W-1:0] low;
    } ovr_regs_t;

endpackage

// File: rtl/shim_cmd_decode.sv
module shim_cmd_decode
    import shim_pkg::*;
(
    input  cmd_pins_t cmd,
    output cmd_kind_e kind
);

    always_comb begin
        kind = CMD_PASS;
        if (!cmd.cs_n && !cmd.ras_n && !cmd.we_n) begin
            if (!cmd.cas_n) begin
                kind = CMD_LMR;
            end else begin
                kind = CMD_PRE;
            end
        end
    end

endmodule

// File: rtl/shim_regs.sv
module shim_regs
    import shim_pkg::*;
#(
    parameter int REG_W = SHIM_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output ovr_regs_t        regs_q
);

    ovr_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_sel) begin
                regs_d.arm  = wr_data[CTL_ARM_BIT];
                regs_d.bank = wr_data[CTL_BA_HI:CTL_BA_LO];
                regs_d.a10  = wr_data[CTL_A10_BIT];
            end else begin
                regs_d.low  = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/shim_addr_mux.sv
module shim_addr_mux
    import shim_pkg::*;
#(
    parameter int ADDR_W = SHIM_ADDR_W,
    parameter int BA_W   = SHIM_BA_W,
    parameter int LOW_W  = SHIM_REG_W
) (
    input  ovr_regs_t         regs,
    input  cmd_kind_e         kind,
    input  logic [BA_W-1:0]   ba_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [BA_W-1:0]   ba_sel,
    output logic [ADDR_W-1:0] addr_sel
);

    logic              take;
    logic [ADDR_W-1:0] ovr_addr;

    // Each address bit takes its override source from its position
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < LOW_W) begin : g_low
            assign ovr_addr[i] = regs.low[i];
        end else if (i == HI_ADDR_POS) begin : g_a10
            assign ovr_addr[i] = regs.a10;
        end else begin : g_zero
            assign ovr_addr[i] = 1'b0;
        end
    end

    always_comb begin
        take     = regs.arm && (kind != CMD_PASS);
        ba_sel   = take ? regs.bank : ba_in;
        addr_sel = take ? ovr_addr  : addr_in;
    end

endmodule

// File: rtl/shim_out_stage.sv
module shim_out_stage
    import shim_pkg::*;
#(
    parameter int ADDR_W = SHIM_ADDR_W,
    parameter int BA_W   = SHIM_BA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_pins_t         cmd_in,
    input  logic [BA_W-1:0]   ba_in,
    input  logic [ADDR_W-1:0] addr_in,
    output cmd_pins_t         cmd_out,
    output logic [BA_W-1:0]   ba_out,
    output logic [ADDR_W-1:0] addr_out
);

    typedef struct packed {
        cmd_pins_t         cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } out_t;

    localparam out_t OUT_IDLE = '{cmd: '{1'b1, 1'b1, 1'b1, 1'b1}, ba: '0, addr: '0};

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d.cmd  = cmd_in;
        out_d.ba   = ba_in;
        out_d.addr = addr_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= OUT_IDLE;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmd_out  = out_q.cmd;
    assign ba_out   = out_q.ba;
    assign addr_out = out_q.addr;

endmodule

// File: rtl/mr_addr_shim.sv
module mr_addr_shim
    import shim_pkg::*;
#(
    parameter int ADDR_W = SHIM_ADDR_W,
    parameter int BA_W   = SHIM_BA_W,
    parameter int REG_W  = SHIM_REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    cmd_pins_t         cmd_in;
    cmd_pins_t         cmd_out;
    cmd_kind_e         kind;
    ovr_regs_t         regs_q;
    logic [BA_W-1:0]   ba_sel;
    logic [ADDR_W-1:0] addr_sel;

    assign cmd_in = '{cs_n: cs_n_i, ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};

    shim_regs #(.REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_we),
        .wr_sel  (host_sel),
        .wr_data (host_wdata),
        .regs_q  (regs_q)
    );

    shim_cmd_decode u_dec (
        .cmd  (cmd_in),
        .kind (kind)
    );

    shim_addr_mux #(.ADDR_W(ADDR_W), .BA_W(BA_W), .LOW_W(REG_W)) u_mux (
        .regs     (regs_q),
        .kind     (kind),
        .ba_in    (ba_i),
        .addr_in  (addr_i),
        .ba_sel   (ba_sel),
        .addr_sel (addr_sel)
    );

    shim_out_stage #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_in   (cmd_in),
        .ba_in    (ba_sel),
        .addr_in  (addr_sel),
        .cmd_out  (cmd_out),
        .ba_out   (ba_o),
        .addr_out (addr_o)
    );

    assign cs_n_o  = cmd_out.cs_n;
    assign ras_n_o = cmd_out.ras_n;
    assign cas_n_o = cmd_out.cas_n;
    assign we_n_o  = cmd_out.we_n;

endmodule

// File: rtl/shim_chk.sv
module shim_chk
    import shim_pkg::*;
#(
    parameter int ADDR_W = SHIM_ADDR_W,
    parameter int BA_W   = SHIM_BA_W,
    parameter int REG_W  = SHIM_REG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic              host_sel,
    input logic [REG_W-1:0]  host_wdata,
    input logic              cs_n_i,
    input logic              ras_n_i,
    input logic              cas_n_i,
    input logic              we_n_i,
    input logic [BA_W-1:0]   ba_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [BA_W-1:0]   ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input ovr_regs_t         regs_q
);

    logic hit;
    logic [ADDR_W-1:0] hi_mask;

    assign hit = regs_q.arm && !cs_n_i && !ras_n_i && !we_n_i;

    always_comb begin
        hi_mask = '1;
        hi_mask[REG_W-1:0] = '0;
        hi_mask[HI_ADDR_POS] = 1'b0;
    end

    // R3
    cmd_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> {cs_n_o, ras_n_o, cas_n_o, we_n_o} ==
                 $past({cs_n_i, ras_n_i, cas_n_i, we_n_i}));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (ba_o == $past(ba_i)) && (addr_o == $past(addr_i)));

    // R7
    bank_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ba_o == $past(regs_q.bank));

    // R8
    addr_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (addr_o[REG_W-1:0] == $past(regs_q.low)) &&
                (addr_o[HI_ADDR_POS] == $past(regs_q.a10)) &&
                ((addr_o & hi_mask) == '0));

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel) |=> (regs_q.arm == $past(host_wdata[CTL_ARM_BIT])) &&
                                  (regs_q.bank == $past(host_wdata[CTL_BA_HI:CTL_BA_LO])) &&
                                  (regs_q.a10 == $past(host_wdata[CTL_A10_BIT])));

    // R2
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_sel) |=> regs_q.low == $past(host_wdata));

    // R2
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> $stable(regs_q));

endmodule

bind mr_addr_shim shim_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W), .REG_W(REG_W)) u_shim_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .cs_n_i     (cs_n_i),
    .ras_n_i    (ras_n_i),
    .cas_n_i    (cas_n_i),
    .we_n_i     (we_n_i),
    .ba_i       (ba_i),
    .addr_i     (addr_i),
    .cs_n_o     (cs_n_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o),
    .ba_o       (ba_o),
    .addr_o     (addr_o),
    .regs_q     (regs_q)
);

// File: tb/tb_mr_addr_shim.sv
`timescale 1ns/1ps
module tb_mr_addr_shim;

    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_DES = 4'b1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [3:0]  cmd = 4'b1111;
    logic [1:0]  ba_i = '0;
    logic [13:0] addr_i = '0;
    logic        cs_n_o, ras_n_o, cas_n_o, we_n_o;
    logic [1:0]  ba_o;
    logic [13:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_a = '0;
    logic [7:0] m_b = '0;

    always #2.5 clk = ~clk;

    mr_addr_shim dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .cs_n_i(cmd[3]), .ras_n_i(cmd[2]), .cas_n_i(cmd[1]), .we_n_i(cmd[0]),
        .ba_i(ba_i), .addr_i(addr_i),
        .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .ba_o(ba_o), .addr_o(addr_o)
    );

    function automatic bit is_sub(input logic [3:0] c, input logic [7:0] b);
        return b[7] && (c == C_LMR || c == C_PRE);
    endfunction

    function automatic logic [13:0] exp_addr(input logic [3:0] c, input logic [13:0] a,
                                             input logic [7:0] ra, input logic [7:0] rb);
        return is_sub(c, rb) ? {3'b000, rb[2], 2'b00, ra} : a;
    endfunction

    function automatic logic [1:0] exp_ba(input logic [3:0] c, input logic [1:0] b,
                                          input logic [7:0] rb);
        return is_sub(c, rb) ? rb[6:5] : b;
    endfunction

    task automatic compare(input string tag, input logic [3:0] ec,
                           input logic [1:0] eb, input logic [13:0] ea);
        checks++;
        if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} != ec || ba_o != eb || addr_o != ea) begin
            errors++;
            $display("FAIL %s: got cmd=%b ba=%b addr=%h, expected cmd=%b ba=%b addr=%h",
                     tag, {cs_n_o, ras_n_o, cas_n_o, we_n_o}, ba_o, addr_o, ec, eb, ea);
        end
    endtask

    // Called at a falling edge: drives one cycle, then checks after the rising edge
    task automatic cyc(input logic [3:0] c, input logic [1:0] b, input logic [13:0] a,
                       input logic we, input logic sel, input logic [7:0] d, input string tag);
        logic [1:0]  eb;
        logic [13:0] ea;
        cmd = c; ba_i = b; addr_i = a;
        host_we = we; host_sel = sel; host_wdata = d;
        eb = exp_ba(c, b, m_b);
        ea = exp_addr(c, a, m_a, m_b);
        @(posedge clk);
        if (we) begin
            if (sel) m_b = d; else m_a = d;
        end
        @(negedge clk);
        host_we = 1'b0;
        compare(tag, c, eb, ea);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        cyc(C_NOP, 2'b00, 14'h0, 1'b1, sel, d, "R2");
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] lst [8];
        lst = '{C_LMR, C_PRE, C_NOP, C_ACT, C_RD, C_WR, C_REF, C_DES};
        void'($urandom(32'h5EED_0017));

        // R1: reset state
        repeat (3) @(negedge clk);
        compare("R1", 4'b1111, 2'b00, 14'h0);
        rst_n = 1'b1;
        // R1: override off after reset, LMR passes through
        cyc(C_LMR, 2'b01, 14'h3ABC, 1'b0, 1'b0, 8'h00, "R1");

        // R3/R4: plain commands pass
        cyc(C_ACT, 2'b10, 14'h1234, 1'b0, 1'b0, 8'h00, "R4");
        cyc(C_RD,  2'b11, 14'h2F0F, 1'b0, 1'b0, 8'h00, "R3");

        // R5/R7/R8: EMR(2)-style load, C4h
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hC4);
        cyc(C_LMR, 2'b00, 14'h3FFF, 1'b0, 1'b0, 8'h00, "R5");
        cyc(C_ACT, 2'b01, 14'h3FFF, 1'b0, 1'b0, 8'h00, "R4");

        // R11: precharge then load, same A10
        cyc(C_PRE, 2'b11, 14'h0000, 1'b0, 1'b0, 8'h00, "R11");
        cyc(C_LMR, 2'b11, 14'h0000, 1'b0, 1'b0, 8'h00, "R11");

        // R6/R7: E0h, PRE
        wr(1'b1, 8'hE0);
        cyc(C_PRE, 2'b00, 14'h3FFF, 1'b0, 1'b0, 8'h00, "R6");

        // R8: low bits, DLL and drive bits
        wr(1'b0, 8'h03);
        cyc(C_LMR, 2'b00, 14'h3F00, 1'b0, 1'b0, 8'h00, "R8");

        // R10: ignored control bits 4,3,1,0
        wr(1'b1, 8'hC4 | 8'h1B);
        m_b = 8'hC4;
        cyc(C_LMR, 2'b01, 14'h2222, 1'b0, 1'b0, 8'h00, "R10");
        wr(1'b1, 8'hE0 | 8'h1B);
        m_b = 8'hE0;
        cyc(C_PRE, 2'b00, 14'h0400, 1'b0, 1'b0, 8'h00, "R10");

        // R9: disarmed
        wr(1'b1, 8'h64);
        cyc(C_LMR, 2'b01, 14'h1555, 1'b0, 1'b0, 8'h00, "R9");
        cyc(C_PRE, 2'b10, 14'h2AAA, 1'b0, 1'b0, 8'h00, "R9");

        // R2: write on same edge as LMR uses old contents
        wr(1'b1, 8'hC4);
        wr(1'b0, 8'h5A);
        cyc(C_LMR, 2'b00, 14'h0000, 1'b1, 1'b1, 8'hE0, "R2");
        cyc(C_LMR, 2'b00, 14'h0000, 1'b1, 1'b0, 8'hA5, "R2");
        cyc(C_PRE, 2'b00, 14'h0000, 1'b0, 1'b0, 8'h00, "R2");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  c;
            logic        we;
            logic [7:0]  d;
            c  = ($urandom % 3 == 0) ? lst[$urandom % 8] : lst[$urandom % 2];
            we = ($urandom % 4 == 0);
            d  = $urandom;
            cyc(c, 2'($urandom), 14'($urandom), we, 1'($urandom),
                d, is_sub(c, m_b) ? "R7_R8" : "R4");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule